// File: doc/BRIEF.md
# Presettable Synchronous Cascadable Counter Stage

This block is one stage of a synchronous counter. A single stage holds a small count value that advances on the rising clock edge. A build-time parameter sets how the count wraps: it either runs through ten states, 0 to 9, or through every binary state, 0 to 15 for the default width. Every output bit is updated by the same clock edge, so logic that decodes the count sees no ripple glitches.

Four control inputs set what happens on each edge. An active-low clear returns the count to zero. A second build-time parameter decides whether the clear acts at once or waits for the next clock edge. An active-low load copies the data inputs into the count on a clock edge. A count enable and a carry-in must both be high for the count to advance. The priority order is clear, then load, then count.

Wider counters are built from several stages. All stages share one clock. The carry-out of each stage drives the carry-in of the next stage, and the carry-in of the first stage is held high. When the clear is synchronous, a shorter count sequence can be made by decoding the value one below the desired wrap point and feeding that decode back into the clear input.

Top module: `sync_count_stage`

## Requirements
- R1: When clr_n, load_n, cnt_en and carry_in are all high, each rising clock edge increases q by one, and all bits of q change on that same edge.
- R2: When a count edge occurs at the terminal value, q wraps to 0. The terminal value is 9 when DECADE=1 and 2**WIDTH-1 (15 for WIDTH=4) when DECADE=0.
- R3: With clr_n and load_n high, q holds its value across clock edges whenever cnt_en is low or carry_in is low.
- R4: With clr_n high and load_n low, a rising edge copies din into q, whatever the values of cnt_en and carry_in.
- R5: A low on clr_n takes precedence over both load and count, so q becomes 0.
- R6: With SYNC_CLEAR=0, q becomes 0 as soon as clr_n goes low, without waiting for a clock edge.
- R7: With SYNC_CLEAR=1, q keeps its value while clr_n is low until the next rising edge, and becomes 0 on that edge.
- R8: carry_out is high exactly when q equals the terminal value and carry_in is high. It follows carry_in combinationally, within the same cycle.
- R9: With DECADE=1, a value from 10 to 15 (for example one that was loaded) gives carry_out low, and the next count edge takes q to 0.
- R10: With SYNC_CLEAR=1, feeding clr_n from an inverted decode of q==6 makes the stage count through 0..6 and never above 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge except an asynchronous clear |
| clr_n | input | 1 | Active-low clear to zero; acts immediately or on the next edge depending on SYNC_CLEAR |
| load_n | input | 1 | Active-low parallel load, taken on the rising edge |
| cnt_en | input | 1 | Count enable |
| carry_in | input | 1 | Carry from the previous stage; also gates carry_out |
| din | input | WIDTH | Value captured by a load |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | High at the terminal value while carry_in is high |

## Verification
The bench builds two instances side by side, and both receive the same stimulus. The first uses DECADE=1 with SYNC_CLEAR=1. It exercises the wrap after nine, the recovery from out-of-range loaded values, the clear that waits for the next edge, and the shortened 0..6 sequence made by feeding a decode of q back into clear. The second uses DECADE=0 with SYNC_CLEAR=0. It covers the full binary wrap after fifteen and shows the immediate clear: clr_n is dropped between edges and the count is checked before the next edge arrives.

// File: rtl/cnt_stage_pkg.sv
`timescale 1ns/1ps
// Package: shared operation encoding and terminal-value helper for the
// counter stage. Assumes decade mode is only used with WIDTH >= 4.
package cnt_stage_pkg;

    // Operation chosen for the next rising edge, listed lowest priority first
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } stage_op_e;

    // Highest legal count: nine in decade mode, all ones otherwise
    function automatic int unsigned term_value(int unsigned width, bit decade);
        if (decade) begin
            return 9;
        end
        return (32'd1 << width) - 32'd1;
    endfunction

endpackage

// File: rtl/cnt_stage_ctrl.sv
`timescale 1ns/1ps
// Module: cnt_stage_ctrl
// Resolves the four active controls into one operation, applying the fixed
// priority clear > load > count > hold. Purely combinational.
module cnt_stage_ctrl
    import cnt_stage_pkg::*;
(
    input  logic      clr_n,
    input  logic      load_n,
    input  logic      cnt_en,
    input  logic      carry_in,
    output stage_op_e op
);

    // Priority decode of the control inputs
    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (cnt_en && carry_in) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/cnt_stage_next.sv
`timescale 1ns/1ps
// Module: cnt_stage_next
// Computes the value the register takes on the next edge. A count at or
// above the terminal value wraps to zero, so out-of-range states in decade
// mode leave on the first count edge.
module cnt_stage_next
    import cnt_stage_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned TERM  = 15
) (
    input  stage_op_e          op,
    input  logic [WIDTH-1:0]   q,
    input  logic [WIDTH-1:0]   din,
    output logic [WIDTH-1:0]   d
);

    localparam logic [WIDTH-1:0] TERM_Q = TERM[WIDTH-1:0];
    localparam logic [WIDTH-1:0] ONE_Q  = {{(WIDTH-1){1'b0}}, 1'b1};

    // Select the next count from the resolved operation
    always_comb begin
        unique case (op)
            OP_CLEAR: d = '0;
            OP_LOAD:  d = din;
            OP_COUNT: d = (q >= TERM_Q) ? '0 : q + ONE_Q;
            default:  d = q;
        endcase
    end

endmodule

// File: rtl/cnt_stage_term.sv
`timescale 1ns/1ps
// Module: cnt_stage_term
// Terminal-value detect and carry generation for chaining stages. The
// carry is combinational so a chain settles within one clock period.
module cnt_stage_term #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned TERM  = 15
) (
    input  logic [WIDTH-1:0] q,
    input  logic             carry_in,
    output logic             carry_out
);

    localparam logic [WIDTH-1:0] TERM_Q = TERM[WIDTH-1:0];

    logic at_term;

    // Flag the exact terminal value; out-of-range values never match
    always_comb begin
        at_term = (q == TERM_Q);
    end

    // Pass the carry onward only from the terminal value
    always_comb begin
        carry_out = at_term && carry_in;
    end

endmodule

// File: rtl/cnt_stage_reg.sv
`timescale 1ns/1ps
// Module: cnt_stage_reg
// Count register. SYNC_CLEAR=1 gives a plain clocked register (the clear is
// already folded into d); SYNC_CLEAR=0 adds an asynchronous active-low clear.
module cnt_stage_reg #(
    parameter int unsigned WIDTH      = 4,
    parameter bit          SYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (SYNC_CLEAR) begin : g_sync
            // Capture the next value; clearing arrives through d
            always_ff @(posedge clk) begin
                q <= d;
            end
        end else begin : g_async
            // Capture the next value, forced to zero while clear is low
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sync_count_stage.sv
`timescale 1ns/1ps
// Module: sync_count_stage
// One presettable synchronous counter stage with carry chaining.
// DECADE selects a 0..9 or full binary sequence; SYNC_CLEAR selects a clear
// taken on the clock edge or one applied immediately. Assumes WIDTH >= 4
// when DECADE is set.
module sync_count_stage
    import cnt_stage_pkg::*;
#(
    parameter int unsigned WIDTH      = 4,
    parameter bit          DECADE     = 1'b0,
    parameter bit          SYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);

    localparam int unsigned TERM = term_value(WIDTH, DECADE);

    stage_op_e        op;
    logic [WIDTH-1:0] d;

    cnt_stage_ctrl u_ctrl (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .carry_in (carry_in),
        .op       (op)
    );

    cnt_stage_next #(.WIDTH(WIDTH), .TERM(TERM)) u_next (
        .op  (op),
        .q   (q),
        .din (din),
        .d   (d)
    );

    cnt_stage_reg #(.WIDTH(WIDTH), .SYNC_CLEAR(SYNC_CLEAR)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (d),
        .q     (q)
    );

    cnt_stage_term #(.WIDTH(WIDTH), .TERM(TERM)) u_term (
        .q         (q),
        .carry_in  (carry_in),
        .carry_out (carry_out)
    );

endmodule

// File: rtl/sync_count_stage_chk.sv
`timescale 1ns/1ps
// Module: sync_count_stage_chk
// Port-level properties for sync_count_stage, attached by bind. All
// clocked properties are disabled while the clear is low.
module sync_count_stage_chk
    import cnt_stage_pkg::*;
#(
    parameter int unsigned WIDTH  = 4,
    parameter bit          DECADE = 1'b0
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             cnt_en,
    input logic             carry_in,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             carry_out
);

    localparam int unsigned      TERM   = term_value(WIDTH, DECADE);
    localparam logic [WIDTH-1:0] TERM_Q = TERM[WIDTH-1:0];
    localparam logic [WIDTH-1:0] ONE_Q  = {{(WIDTH-1){1'b0}}, 1'b1};

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && carry_in && q < TERM_Q) |=> (q == $past(q) + ONE_Q));

    // R2 R9
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && carry_in && q >= TERM_Q) |=> (q == '0));

    // R3
    hold_value_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && carry_in)) |=> $stable(q));

    // R4
    load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!load_n) |=> (q == $past(din)));

    // R8
    carry_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (carry_in && q == TERM_Q));

    // R8
    carry_raise_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (carry_in && q == TERM_Q) |-> carry_out);

endmodule

bind sync_count_stage sync_count_stage_chk #(
    .WIDTH  (WIDTH),
    .DECADE (DECADE)
) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .cnt_en    (cnt_en),
    .carry_in  (carry_in),
    .din       (din),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/sim_sync_count_stage.sv
`timescale 1ns/1ps
// Bench: two stages on shared stimulus, each compared on every falling edge
// against a behavioural model kept in integers.
module sim_sync_count_stage;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0, load_n = 1'b1, cnt_en = 1'b0, carry_in = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q0, q1;
    logic         co0, co1;

    int    m0 = 0, m1 = 0;
    int    n_chk = 0, n_fail = 0;
    bit    live = 1'b0;
    string phase = "R5";

    always #(CLK_PERIOD/2) clk = ~clk;

    // Decade stage with a clocked clear
    sync_count_stage #(.WIDTH(W), .DECADE(1'b1), .SYNC_CLEAR(1'b1)) u0 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_in(carry_in), .din(din), .q(q0), .carry_out(co0));

    // Binary stage with an immediate clear
    sync_count_stage #(.WIDTH(W), .DECADE(1'b0), .SYNC_CLEAR(1'b0)) u1 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_in(carry_in), .din(din), .q(q1), .carry_out(co1));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int step(input int m, input int term);
        if (!clr_n) return 0;
        if (!load_n) return int'(din);
        if (cnt_en && carry_in) return (m >= term) ? 0 : m + 1;
        return m;
    endfunction

    // Model update on the rising edge
    always @(posedge clk) begin
        m0 = step(m0, 9);
        m1 = step(m1, 15);
    end

    // Immediate clear of the binary stage's model
    always @(negedge clr_n) m1 = 0;

    // Per-cycle comparison against the models
    always @(negedge clk) begin
        if (live) begin
            chk({phase, " u0 q"}, int'(q0), m0);
            chk({phase, " u1 q"}, int'(q1), m1);
            chk({phase, " u0 carry R8"}, int'(co0), int'(m0 == 9 && carry_in));
            chk({phase, " u1 carry R8"}, int'(co1), int'(m1 == 15 && carry_in));
        end
    end

    task automatic run(input logic c, input logic l, input logic e,
                       input logic ci, input logic [W-1:0] d, input int n);
        @(negedge clk);
        #1;
        clr_n = c; load_n = l; cnt_en = e; carry_in = ci; din = d;
        repeat (n) @(posedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int mx;
        int hits;
        // R5 reset state under clear
        run(1'b0, 1'b1, 1'b0, 1'b0, '0, 2);
        live = 1'b1;
        @(negedge clk); #1;
        chk("R5 reset u0", int'(q0), 0);
        chk("R5 reset u1", int'(q1), 0);

        // R1 R2: free counting through both wrap points
        phase = "R1 R2";
        run(1'b1, 1'b1, 1'b1, 1'b1, '0, 22);

        // R3: each enable low stops counting
        phase = "R3";
        run(1'b1, 1'b1, 1'b0, 1'b1, '0, 3);
        run(1'b1, 1'b1, 1'b1, 1'b0, '0, 3);

        // R4: load with enables low, then load and count across terminal
        phase = "R4";
        run(1'b1, 1'b0, 1'b0, 1'b0, 4'd7, 1);
        @(negedge clk); #1;
        chk("R4 load u0", int'(q0), 7);
        run(1'b1, 1'b0, 1'b1, 1'b1, 4'd8, 1);
        phase = "R4 R8";
        run(1'b1, 1'b1, 1'b1, 1'b1, '0, 3);

        // R5: clear wins over a simultaneous load
        phase = "R5";
        run(1'b0, 1'b0, 1'b1, 1'b1, 4'd5, 1);
        @(negedge clk); #1;
        chk("R5 priority u0", int'(q0), 0);
        chk("R5 priority u1", int'(q1), 0);

        // R6 R7: clear dropped between edges
        phase = "R6 R7";
        run(1'b1, 1'b1, 1'b1, 1'b1, '0, 4);
        @(negedge clk); #1;
        clr_n = 1'b0;
        #1;
        chk("R6 immediate clear u1", int'(q1), 0);
        chk("R7 clear waits for edge u0", int'(q0), 4);
        @(negedge clk); #1;
        chk("R7 cleared on edge u0", int'(q0), 0);
        clr_n = 1'b1;

        // R9: out-of-range loads in decade mode
        phase = "R9";
        run(1'b1, 1'b0, 1'b0, 1'b1, 4'd12, 1);
        @(negedge clk); #1;
        chk("R9 carry low at 12", int'(co0), 0);
        run(1'b1, 1'b1, 1'b1, 1'b1, '0, 1);
        @(negedge clk); #1;
        chk("R9 12 returns to 0", int'(q0), 0);
        chk("R9 binary 12 to 13", int'(q1), 13);
        run(1'b1, 1'b0, 1'b0, 1'b1, 4'd15, 1);
        run(1'b1, 1'b1, 1'b1, 1'b1, '0, 2);

        // R10: shortened sequence by feeding back a decode of six
        phase = "R10";
        mx = 0;
        hits = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #1;
            if (int'(q0) > mx) mx = int'(q0);
            if (q0 == 4'd6) hits++;
            clr_n = (q0 == 4'd6) ? 1'b0 : 1'b1;
        end
        chk("R10 highest value", mx, 6);
        chk("R10 six reached repeatedly", int'(hits >= 3), 1);
        @(negedge clk); #1;
        clr_n = 1'b1;
        @(negedge clk);
        #2;
        summary();
        $finish;
    end

endmodule